// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses of one memory burst, one address per clock. A single-cycle start strobe registers a starting column, a burst length code and an order select. The block then steps through the burst. Fixed bursts of 2, 4 or 8 beats stay inside an aligned block of that many columns. The first beat is the requested column. Later beats either count upward and wrap inside the block, or take the starting offset XOR the beat number.

A page-length burst starts at any column of the 512-column row and counts upward, wrapping around the row. It runs until a stop input is seen. Page-length bursts support only the upward order. Asking for the other order raises an error flag and the burst runs in upward order. Another start strobe at any time drops the running burst and begins the new one.

Top module: `col_burst_seq`

## Requirements
- R1: While reset is low at a clock edge, and after that edge, `valid_o`, `last_o` and `err_o` are 0.
- R2: The length code on `blen_i` is decoded as 0 = 1 beat, 1 = 2 beats, 2 = 4 beats, 3 = 8 beats, and 4 to 7 = page length. A start sampled at edge n gives the first beat after edge n and one beat after each later edge. A fixed burst of L beats has exactly L beats, and `last_o` is 1 on the final beat only.
- R3: In a fixed burst of L beats, the column bits above the low log2(L) bits equal those of the start column on every beat.
- R4: With `ileave_i` = 0 and a fixed length L, beat k has in-block offset (s + k) mod L, where s is the start column mod L.
- R5: With `ileave_i` = 1 and a fixed length of 2, 4 or 8, beat k has in-block offset s XOR k.
- R6: A 1-beat burst presents the start column once with `last_o` = 1, whatever the value of `ileave_i`.
- R7: A page-length burst begins at the start column and adds 1 per beat modulo 512. `last_o` stays 0, and the burst ends after the edge at which `stop_i` is sampled high.
- R8: A page-length burst started with `ileave_i` = 1 holds `err_o` at 1 on each of its beats and still runs in upward order. `err_o` is 0 whenever `valid_o` is 0.
- R9: A start sampled during a burst discards it, and the new burst's first beat follows that edge. A start sampled together with `stop_i` wins over the stop.
- R10: `stop_i` has no effect on a fixed-length burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a burst with the values on the inputs below |
| start_col_i | input | 9 | Starting column |
| blen_i | input | 3 | Burst length code |
| ileave_i | input | 1 | 1 = XOR order, 0 = upward order |
| stop_i | input | 1 | Ends a page-length burst |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | A beat is present on `col_o` |
| last_o | output | 1 | Final beat of a fixed-length burst |
| err_o | output | 1 | XOR order was asked for a page-length burst |

## Verification
The assertions assume that start fields are meaningful only in the cycle that `start_i` is high. They also assume that `stop_i` may arrive at any time, so the address-step properties exclude cycles with a start or a stop. The stimulus holds `start_i` high for exactly one cycle per burst. Its directed and random sequences include starts that land mid-burst, starts on the final beat, stops during fixed bursts, and start and stop in the same cycle. A behavioural model predicts every output on every cycle.

// File: rtl/col_seq_pkg.sv
// Shared definitions for the burst column sequencer.
// Assumes: length codes 4 to 7 all mean page length.
package col_seq_pkg;
    localparam int BLEN_W = 3;

    typedef enum logic [BLEN_W-1:0] {
        BLEN_ONE   = 3'd0,
        BLEN_TWO   = 3'd1,
        BLEN_FOUR  = 3'd2,
        BLEN_EIGHT = 3'd3,
        BLEN_PAGE  = 3'd7
    } blen_code_e;
endpackage

// File: rtl/col_seq_decode.sv
// Turns the length code and order bit into an offset mask, a page flag,
// an effective order and an error flag.
// Assumes: COL_W >= 4, so an 8-beat mask fits.
module col_seq_decode
    import col_seq_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [BLEN_W-1:0] blen_code,
    input  logic              ileave,
    output logic [COL_W-1:0]  mask,
    output logic              page,
    output logic              ilv_eff,
    output logic              err
);
    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    // Purpose: derive the in-block mask and the mode flags from the code.
    always_comb begin
        page = blen_code[BLEN_W-1];
        if (page) begin
            mask = '1;
        end else begin
            mask = (ONE << blen_code[1:0]) - ONE;
        end
        ilv_eff = ileave && !page;
        err     = ileave && page;
    end
endmodule

// File: rtl/col_seq_ctrl.sv
// Holds the burst state: active flag, beat counter and the captured
// configuration. Start has priority over stop and over the end of a burst.
// Assumes: the decoded configuration is valid in the cycle start is high.
module col_seq_ctrl #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic [COL_W-1:0] col_d,
    input  logic [COL_W-1:0] mask_d,
    input  logic             page_d,
    input  logic             ilv_d,
    input  logic             err_d,
    output logic             active,
    output logic [COL_W-1:0] cnt,
    output logic [COL_W-1:0] base_q,
    output logic [COL_W-1:0] mask_q,
    output logic             page_q,
    output logic             ilv_q,
    output logic             err_q,
    output logic             final_beat
);
    logic at_end;

    // Purpose: a fixed burst has reached its final beat.
    always_comb at_end = !page_q && (cnt == mask_q);

    // Purpose: load a burst on start, count beats, end on length or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            base_q <= '0;
            mask_q <= '0;
            page_q <= 1'b0;
            ilv_q  <= 1'b0;
            err_q  <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
            base_q <= col_d;
            mask_q <= mask_d;
            page_q <= page_d;
            ilv_q  <= ilv_d;
            err_q  <= err_d;
        end else if (active) begin
            if ((page_q && stop) || at_end) begin
                active <= 1'b0;
                err_q  <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Purpose: mark the final beat of a fixed burst.
    always_comb final_beat = active && at_end;
endmodule

// File: rtl/col_seq_addr.sv
// Forms the column of the current beat. Bits outside the mask come from
// the start column. Bits inside the mask come from either start + count
// or start XOR count.
// Assumes: cnt never exceeds mask in XOR order.
module col_seq_addr #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] cnt,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] off;

    // Purpose: pick the in-block offset and merge it with the fixed bits.
    always_comb begin
        off = ilv ? (base ^ cnt) : (base + cnt);
        col = (base & ~mask) | (off & mask);
    end
endmodule

// File: rtl/col_burst_seq.sv
// Top level of the burst column sequencer: decode, state, address forming.
// Assumes: start_i is a one-cycle strobe, and its fields are valid with it.
module col_burst_seq
    import col_seq_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [BLEN_W-1:0] blen_i,
    input  logic              ileave_i,
    input  logic              stop_i,
    output logic [COL_W-1:0]  col_o,
    output logic              valid_o,
    output logic              last_o,
    output logic              err_o
);
    logic [COL_W-1:0] mask_d, mask_q, cnt, base_q;
    logic             page_d, ilv_d, err_d;
    logic             page_q, ilv_q, err_q, active, final_beat;

    col_seq_decode #(.COL_W(COL_W)) u_decode (
        .blen_code (blen_i),
        .ileave    (ileave_i),
        .mask      (mask_d),
        .page      (page_d),
        .ilv_eff   (ilv_d),
        .err       (err_d)
    );

    col_seq_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_i),
        .stop       (stop_i),
        .col_d      (start_col_i),
        .mask_d     (mask_d),
        .page_d     (page_d),
        .ilv_d      (ilv_d),
        .err_d      (err_d),
        .active     (active),
        .cnt        (cnt),
        .base_q     (base_q),
        .mask_q     (mask_q),
        .page_q     (page_q),
        .ilv_q      (ilv_q),
        .err_q      (err_q),
        .final_beat (final_beat)
    );

    col_seq_addr #(.COL_W(COL_W)) u_addr (
        .base (base_q),
        .cnt  (cnt),
        .mask (mask_q),
        .ilv  (ilv_q),
        .col  (col_o)
    );

    // Purpose: drive the status outputs from the burst state.
    always_comb begin
        valid_o = active;
        last_o  = final_beat;
        err_o   = err_q && active;
    end
endmodule

// File: rtl/col_burst_seq_chk.sv
// Property checker for col_burst_seq, attached by bind.
// Assumes: mask_q, page_q and ilv_q are the captured burst configuration.
module col_burst_seq_chk #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             stop_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o,
    input logic             err_o,
    input logic [COL_W-1:0] mask_q,
    input logic             page_q,
    input logic             ilv_q
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && !last_o && !err_o));

    assert_last_in_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    assert_end_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o);

    assert_upper_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !start_i && !page_q)
        |=> ((col_o & ~mask_q) == ($past(col_o) & ~mask_q)));

    assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !start_i && !stop_i && !ilv_q)
        |=> ((col_o & mask_q) == (COL_W'($past(col_o) + 1'b1) & mask_q)));

    assert_no_last_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && page_q) |-> !last_o);

    assert_page_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && page_q && stop_i && !start_i) |=> !valid_o);

    assert_err_in_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (valid_o && page_q));

    assert_start_takes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o);
endmodule

bind col_burst_seq col_burst_seq_chk #(.COL_W(COL_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .stop_i  (stop_i),
    .col_o   (col_o),
    .valid_o (valid_o),
    .last_o  (last_o),
    .err_o   (err_o),
    .mask_q  (mask_q),
    .page_q  (page_q),
    .ilv_q   (ilv_q)
);

// File: tb/test_col_burst_seq.sv
`timescale 1ns/1ps
module test_col_burst_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [8:0] start_col_i = '0;
    logic [2:0] blen_i = '0;
    logic       ileave_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [8:0] col_o;
    logic       valid_o, last_o, err_o;

    int    checks = 0;
    int    fails = 0;
    string cur_req = "R1";

    // Behavioural reference state
    int q[$];
    int m_col = 0;
    bit m_valid = 0, m_last = 0, m_err = 0, m_page = 0;

    col_burst_seq i_col_burst_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .blen_i(blen_i), .ileave_i(ileave_i), .stop_i(stop_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
    );

    always #4 clk = ~clk;

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int len, off, hi;
        if (!rst_n) begin
            m_valid = 0; m_last = 0; m_err = 0; m_page = 0; q.delete();
        end else if (start_i) begin
            q.delete();
            m_page  = (blen_i >= 4);
            m_err   = ileave_i && m_page;
            m_valid = 1;
            if (m_page) begin
                m_col = start_col_i; m_last = 0;
            end else begin
                len = 1 << blen_i;
                off = start_col_i % len;
                hi  = start_col_i - off;
                for (int k = 0; k < len; k++)
                    q.push_back(hi + (ileave_i ? (off ^ k) : ((off + k) % len)));
                m_col  = q.pop_front();
                m_last = (q.size() == 0);
            end
        end else if (m_valid) begin
            if (m_page) begin
                if (stop_i) begin m_valid = 0; m_err = 0; end
                else m_col = (m_col + 1) % 512;
            end else if (q.size() == 0) begin
                m_valid = 0; m_last = 0;
            end else begin
                m_col  = q.pop_front();
                m_last = (q.size() == 0);
            end
        end
    endtask

    task automatic compare();
        check(cur_req, "valid", valid_o, m_valid);
        if (m_valid) begin
            check(cur_req, "col", col_o, m_col);
            check(cur_req, "last", last_o, m_last);
            check(cur_req, "err", err_o, m_err);
        end else begin
            check(cur_req, "last", last_o, 0);
            check(cur_req, "err", err_o, 0);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic launch(int col, int code, bit il);
        start_i = 1; start_col_i = 9'(col); blen_i = 3'(code); ileave_i = il;
        tick();
        start_i = 0;
    endtask

    task automatic run(int n);
        repeat (n) tick();
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

    initial begin
        // R1: outputs quiet in and after reset
        cur_req = "R1";
        run(3);
        rst_n = 1;
        run(2);

        cur_req = "R4"; launch(5, 3, 0); run(9);     // 5-6-7-0-1-2-3-4
        cur_req = "R5"; launch(5, 3, 1); run(9);     // 5-4-7-6-1-0-3-2
        cur_req = "R3"; launch(9'h1A6, 2, 0); run(5);
        cur_req = "R3"; launch(9'h1A7, 2, 1); run(5);
        cur_req = "R2"; launch(9'h0FF, 1, 0); run(3);
        cur_req = "R2"; launch(9'h0FE, 1, 1); run(3);
        cur_req = "R6"; launch(9'h133, 0, 1); run(2);
        cur_req = "R6"; launch(9'h02A, 0, 0); run(2);

        // R7: page burst wraps past column 511, then stops
        cur_req = "R7"; launch(509, 7, 0); run(6);
        stop_i = 1; tick(); stop_i = 0; run(2);
        // R8: XOR order on page length flags error, runs upward
        cur_req = "R8"; launch(3, 4, 1); run(4);
        stop_i = 1; tick(); stop_i = 0; run(2);

        // R9: restart mid burst, on final beat, and start beating stop
        cur_req = "R9"; launch(2, 3, 0); run(2); launch(12, 2, 1); run(5);
        launch(0, 1, 0); tick(); launch(40, 3, 1); run(9);
        launch(100, 6, 0); run(3);
        stop_i = 1; launch(7, 2, 0); stop_i = 0; run(5);

        // R10: stop during a fixed burst is ignored
        cur_req = "R10"; launch(21, 3, 1);
        stop_i = 1; run(3); stop_i = 0; run(6);

        // Mixed random bursts
        cur_req = "R2";
        for (int b = 0; b < 60; b++) begin
            int code;
            code = $urandom_range(0, 5);
            if (code == 5) code = 4 + $urandom_range(0, 3);
            launch($urandom_range(0, 511), code, $urandom_range(0, 1));
            for (int c = 0; c < $urandom_range(0, 12); c++) begin
                stop_i = ($urandom_range(0, 5) == 0);
                tick();
            end
            stop_i = 0;
        end
        stop_i = 1; run(2); stop_i = 0; run(2);

        $display("  Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end
endmodule